// File: doc/BRIEF.md
# I2C Controller Status Flag Tracker

This block keeps the status flags that software polls on an I2C controller. The bus engine sends it single-cycle event strobes: a start condition was generated, an address phase finished (sent as host or matched as target), what kind of address matched, a byte finished, a stop or start was detected on the bus, and the address was not acknowledged. It also receives the live SDA/SCL levels. The register decoder sends it single-cycle access strobes for reads of the two status words and for writes to the data register. The block turns all of this into two read-only status words.

Several flags can only be cleared by a two-step software sequence. A read of status word 1 arms a single sticky bit. The next data-register write or status-word-2 read uses that bit up, and it clears the flags that belong to that access. The address-match details, the direction flag and the bus-busy flag clear on bus events instead. The interface has no data stream. Every pin is a plain level or a one-cycle strobe, with no valid/ready handshake and no back-pressure.

Top module: `i2c_flag_tracker`

## Requirements
- R1: While rst_n is low, and on the first sample after it is asserted at any time, both status words read zero.
- R2: The start flag (status 1 bit 0) sets one cycle after start_gen. It clears only on a data write while the sequence bit is armed. A data write while the sequence bit is not armed leaves it set.
- R3: The address flag (status 1 bit 1) sets after addr_done when addr_nack is low. When addr_nack is high, an addr_done leaves the address flag, the match flags and the direction flag unchanged.
- R4: The address flag clears on a status-2 read while the sequence bit is armed. A status-2 read while the bit is not armed has no effect.
- R5: A status-1 read arms a single sequence bit. The first data write or status-2 read that follows uses it up. After that, a later status-2 read does not clear an address flag that was set after the data write.
- R6: When a set event and its clearing access fall in the same cycle, the flag ends up set. A stop seen while a bus line is low leaves the busy flag set.
- R7: Each accepted address phase loads the match flags in status 2: bit 5 (0 = own address 1, 1 = own address 2), bit 4 (SMBus host address), bit 3 (SMBus device address) and bit 2 (general call). A stop, a detected start or periph_en low clears all four. periph_en low has priority over an address event in the same cycle.
- R8: The direction flag (status 2 bit 1) loads addr_dir_tx on an accepted address phase (1 = transmit, 0 = receive). It clears on a stop.
- R9: The transfer-complete flag (status 1 bit 2) sets on byte_done only while no_stretch is high. In receive mode it also needs data_unread. In transmit mode it also needs data_empty. It clears like the start flag.
- R10: The busy flag (status 2 bit 0) sets when SDA or SCL is low. It clears on a stop.
- R11: Status 2 bits 15:8 show pec_val one cycle after a cycle with pec_en high, and zero one cycle after a cycle with pec_en low. All status bits not named here read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; low clears the match flags |
| pec_en | input | 1 | PEC enable; low zeroes the PEC field |
| pec_val | input | PEC_W | PEC value from the checksum unit |
| start_gen | input | 1 | Start condition generated |
| addr_done | input | 1 | Address sent (host) or matched (target) |
| addr_nack | input | 1 | Address phase was not acknowledged |
| match_sec | input | 1 | Match was against own address 2 |
| match_host | input | 1 | SMBus host address matched |
| match_dev | input | 1 | SMBus device address matched |
| match_gc | input | 1 | General call address matched |
| addr_dir_tx | input | 1 | Direction of the transfer, 1 = transmit |
| byte_done | input | 1 | A byte finished, including its ACK |
| rx_mode | input | 1 | 1 = receiving, 0 = transmitting |
| data_unread | input | 1 | Receive data register is still unread |
| data_empty | input | 1 | Transmit data register is still empty |
| no_stretch | input | 1 | Clock stretching is disabled |
| bus_stop | input | 1 | Stop condition detected |
| bus_start | input | 1 | Start condition detected on the bus |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| rd_stat1 | input | 1 | Status word 1 read strobe |
| rd_stat2 | input | 1 | Status word 2 read strobe |
| wr_data | input | 1 | Data register write strobe |
| stat1 | output | STAT_W | Status word 1 |
| stat2 | output | STAT_W | Status word 2 |

## Verification
Every flag and the PEC field sit one register away from the pins. A strobe driven in one cycle therefore shows on the status words after the next rising edge, and it is due exactly one cycle after the stimulus. The bench drives each vector on a falling edge, holds it for one clock, and compares the status words at the following falling edge. At that point the single register stage has updated and nothing else has moved. Because the vectors form one continuous sequence, each comparison also shows that the flags not targeted by that vector held their value.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  // status word 1 positions
  localparam int S1_START = 0;
  localparam int S1_ADDR  = 1;
  localparam int S1_TDC   = 2;
  // status word 2 positions
  localparam int S2_BUSY  = 0;
  localparam int S2_DIR   = 1;
  localparam int S2_GC    = 2;
  localparam int S2_DEV   = 3;
  localparam int S2_HOST  = 4;
  localparam int S2_SEC   = 5;

  typedef struct packed {
    logic sec;
    logic host;
    logic dev;
    logic gc;
  } match_t;
endpackage

// File: rtl/i2c_flag_cell.sv
// Single flag with set priority over clear.
module i2c_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/i2c_read_seq.sv
// Sticky "status 1 was read" bit, used up by the first follow-up access.
module i2c_read_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stat1,
  input  logic rd_stat2,
  input  logic wr_data,
  output logic clr_by_wr,
  output logic clr_by_rd
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    armed <= 1'b0;
    else if (rd_stat1)             armed <= 1'b1;
    else if (wr_data || rd_stat2)  armed <= 1'b0;
  end

  assign clr_by_wr = armed & wr_data;
  assign clr_by_rd = armed & rd_stat2;

  p_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat1 |=> armed);
  p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat1 && (wr_data || rd_stat2)) |=> !armed);
endmodule

// File: rtl/i2c_sts1_flags.sv
module i2c_sts1_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_gen,
  input  logic addr_ok,
  input  logic byte_done,
  input  logic rx_mode,
  input  logic data_unread,
  input  logic data_empty,
  input  logic no_stretch,
  input  logic clr_wr,
  input  logic clr_rd,
  output logic start_f,
  output logic addr_f,
  output logic tdc_f
);
  logic tdc_hit;

  assign tdc_hit = no_stretch & byte_done & (rx_mode ? data_unread : data_empty);

  i2c_flag_cell u_start (.clk(clk), .rst_n(rst_n), .set_i(start_gen), .clr_i(clr_wr), .q_o(start_f));
  i2c_flag_cell u_addr  (.clk(clk), .rst_n(rst_n), .set_i(addr_ok),   .clr_i(clr_rd), .q_o(addr_f));
  i2c_flag_cell u_tdc   (.clk(clk), .rst_n(rst_n), .set_i(tdc_hit),   .clr_i(clr_wr), .q_o(tdc_f));

  p_start_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_f && !clr_wr) |=> start_f);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_f && !clr_rd) |=> addr_f);
  p_tdc_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tdc_f && !no_stretch) |=> !tdc_f);
endmodule

// File: rtl/i2c_sts2_flags.sv
module i2c_sts2_flags
  import i2c_flag_pkg::*;
#(
  parameter int PEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             pec_en,
  input  logic [PEC_W-1:0] pec_val,
  input  logic             addr_ok,
  input  match_t           match_in,
  input  logic             dir_tx,
  input  logic             bus_stop,
  input  logic             bus_start,
  input  logic             line_low,
  output match_t           match_q,
  output logic             dir_q,
  output logic             busy_q,
  output logic [PEC_W-1:0] pec_q
);
  logic bus_clr;
  assign bus_clr = bus_stop | bus_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          match_q <= '0;
    else if (!periph_en) match_q <= '0;
    else if (addr_ok)    match_q <= match_in;
    else if (bus_clr)    match_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dir_q <= 1'b0;
    else if (addr_ok)  dir_q <= dir_tx;
    else if (bus_stop) dir_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pec_q <= '0;
    else if (!pec_en) pec_q <= '0;
    else              pec_q <= pec_val;
  end

  i2c_flag_cell u_busy (.clk(clk), .rst_n(rst_n), .set_i(line_low), .clr_i(bus_stop), .q_o(busy_q));

  p_en_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> (match_q == '0));
  p_bus_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_clr && !addr_ok) |=> (match_q == '0));
  p_dir_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && !addr_ok) |=> !dir_q);
  p_pec_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pec_en |=> (pec_q == '0));
  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_low |=> busy_q);
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_flag_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int PEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_en,
  input  logic              pec_en,
  input  logic [PEC_W-1:0]  pec_val,
  input  logic              start_gen,
  input  logic              addr_done,
  input  logic              addr_nack,
  input  logic              match_sec,
  input  logic              match_host,
  input  logic              match_dev,
  input  logic              match_gc,
  input  logic              addr_dir_tx,
  input  logic              byte_done,
  input  logic              rx_mode,
  input  logic              data_unread,
  input  logic              data_empty,
  input  logic              no_stretch,
  input  logic              bus_stop,
  input  logic              bus_start,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic              rd_stat1,
  input  logic              rd_stat2,
  input  logic              wr_data,
  output logic [STAT_W-1:0] stat1,
  output logic [STAT_W-1:0] stat2
);
  localparam int PEC_LSB = STAT_W - PEC_W;

  logic       addr_ok, clr_wr, clr_rd;
  logic       start_f, addr_f, tdc_f;
  logic       dir_q, busy_q;
  match_t     match_in, match_q;
  logic [PEC_W-1:0] pec_q;

  assign addr_ok  = addr_done & ~addr_nack;
  assign match_in = '{sec: match_sec, host: match_host, dev: match_dev, gc: match_gc};

  i2c_read_seq u_seq (
    .clk(clk), .rst_n(rst_n), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .wr_data(wr_data), .clr_by_wr(clr_wr), .clr_by_rd(clr_rd)
  );

  i2c_sts1_flags u_s1 (
    .clk(clk), .rst_n(rst_n), .start_gen(start_gen), .addr_ok(addr_ok),
    .byte_done(byte_done), .rx_mode(rx_mode), .data_unread(data_unread),
    .data_empty(data_empty), .no_stretch(no_stretch), .clr_wr(clr_wr),
    .clr_rd(clr_rd), .start_f(start_f), .addr_f(addr_f), .tdc_f(tdc_f)
  );

  i2c_sts2_flags #(.PEC_W(PEC_W)) u_s2 (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .pec_en(pec_en),
    .pec_val(pec_val), .addr_ok(addr_ok), .match_in(match_in),
    .dir_tx(addr_dir_tx), .bus_stop(bus_stop), .bus_start(bus_start),
    .line_low(~sda_in | ~scl_in), .match_q(match_q), .dir_q(dir_q),
    .busy_q(busy_q), .pec_q(pec_q)
  );

  always_comb begin
    stat1           = '0;
    stat1[S1_START] = start_f;
    stat1[S1_ADDR]  = addr_f;
    stat1[S1_TDC]   = tdc_f;
    stat2           = '0;
    stat2[S2_BUSY]  = busy_q;
    stat2[S2_DIR]   = dir_q;
    stat2[S2_GC]    = match_q.gc;
    stat2[S2_DEV]   = match_q.dev;
    stat2[S2_HOST]  = match_q.host;
    stat2[S2_SEC]   = match_q.sec;
    stat2[STAT_W-1:PEC_LSB] = pec_q;
  end

  p_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_nack && !stat1[S1_ADDR]) |=> !stat1[S1_ADDR]);
  p_addr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_nack) |=> stat1[S1_ADDR]);
  p_stop_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && sda_in && scl_in) |=> !stat2[S2_BUSY]);
endmodule

// File: tb/sim_i2c_flag_tracker.sv
`timescale 1ns/1ps
module sim_i2c_flag_tracker;
  localparam int STAT_W = 16;
  localparam int PEC_W  = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, periph_en, pec_en;
  logic [PEC_W-1:0] pec_val;
  logic start_gen, addr_done, addr_nack, match_sec, match_host, match_dev, match_gc;
  logic addr_dir_tx, byte_done, rx_mode, data_unread, data_empty, no_stretch;
  logic bus_stop, bus_start, sda_in, scl_in, rd_stat1, rd_stat2, wr_data;
  logic [STAT_W-1:0] stat1, stat2;

  i2c_flag_tracker #(.STAT_W(STAT_W), .PEC_W(PEC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .pec_en(pec_en), .pec_val(pec_val),
    .start_gen(start_gen), .addr_done(addr_done), .addr_nack(addr_nack),
    .match_sec(match_sec), .match_host(match_host), .match_dev(match_dev),
    .match_gc(match_gc), .addr_dir_tx(addr_dir_tx), .byte_done(byte_done),
    .rx_mode(rx_mode), .data_unread(data_unread), .data_empty(data_empty),
    .no_stretch(no_stretch), .bus_stop(bus_stop), .bus_start(bus_start),
    .sda_in(sda_in), .scl_in(scl_in), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .wr_data(wr_data), .stat1(stat1), .stat2(stat2)
  );

  // stimulus bits
  localparam logic [19:0] K_0   = 20'h00000;
  localparam logic [19:0] K_SG  = 20'h00001;
  localparam logic [19:0] K_AD  = 20'h00002;
  localparam logic [19:0] K_NK  = 20'h00004;
  localparam logic [19:0] K_SEC = 20'h00008;
  localparam logic [19:0] K_HST = 20'h00010;
  localparam logic [19:0] K_DEV = 20'h00020;
  localparam logic [19:0] K_GC  = 20'h00040;
  localparam logic [19:0] K_TX  = 20'h00080;
  localparam logic [19:0] K_BD  = 20'h00100;
  localparam logic [19:0] K_RX  = 20'h00200;
  localparam logic [19:0] K_UNR = 20'h00400;
  localparam logic [19:0] K_EMP = 20'h00800;
  localparam logic [19:0] K_STP = 20'h01000;
  localparam logic [19:0] K_SDT = 20'h02000;
  localparam logic [19:0] K_R1  = 20'h04000;
  localparam logic [19:0] K_R2  = 20'h08000;
  localparam logic [19:0] K_WR  = 20'h10000;
  localparam logic [19:0] K_SDA = 20'h20000;
  localparam logic [19:0] K_SCL = 20'h40000;
  localparam logic [19:0] K_NS  = 20'h80000;

  // {req, stimulus, expected stat1[2:0] = {tdc,addr,start}, expected stat2[5:0] = {sec,host,dev,gc,dir,busy}}
  localparam int NV = 36;
  localparam logic [32:0] TBL [NV] = '{
    {4'd1,  K_0,                  3'b000, 6'b000000}, // R1 idle
    {4'd10, K_SDA,                3'b000, 6'b000001}, // R10 busy on SDA low
    {4'd2,  K_SG,                 3'b001, 6'b000001}, // R2 start flag set
    {4'd2,  K_WR,                 3'b001, 6'b000001}, // R2 write not armed
    {4'd2,  K_R1,                 3'b001, 6'b000001},
    {4'd2,  K_WR,                 3'b000, 6'b000001}, // R2 armed write clears
    {4'd8,  K_AD|K_TX,            3'b010, 6'b000011}, // R8 dir tx, R3 addr set
    {4'd4,  K_R2,                 3'b010, 6'b000011}, // R4 unarmed read
    {4'd4,  K_R1,                 3'b010, 6'b000011},
    {4'd4,  K_R2,                 3'b000, 6'b000011}, // R4 armed read clears
    {4'd5,  K_R1,                 3'b000, 6'b000011},
    {4'd5,  K_WR,                 3'b000, 6'b000011}, // R5 arm used by write
    {4'd7,  K_AD|K_SEC|K_GC,      3'b010, 6'b100101}, // R7 second address + gc
    {4'd5,  K_R2,                 3'b010, 6'b100101}, // R5 arm already used
    {4'd8,  K_STP,                3'b010, 6'b000000}, // R8/R7/R10 stop
    {4'd4,  K_R1,                 3'b010, 6'b000000},
    {4'd4,  K_R2,                 3'b000, 6'b000000},
    {4'd3,  K_AD|K_NK|K_HST|K_TX, 3'b000, 6'b000000}, // R3 nack ignored
    {4'd7,  K_AD|K_HST|K_DEV,     3'b010, 6'b011000}, // R7 host+device
    {4'd7,  K_SDT,                3'b010, 6'b000000}, // R7 start detect clears
    {4'd6,  K_R1,                 3'b010, 6'b000000},
    {4'd6,  K_AD|K_R2,            3'b010, 6'b000000}, // R6 set wins over read clear
    {4'd6,  K_R2,                 3'b010, 6'b000000},
    {4'd9,  K_NS|K_BD|K_RX|K_UNR, 3'b110, 6'b000000}, // R9 rx tdc
    {4'd9,  K_R1,                 3'b110, 6'b000000},
    {4'd9,  K_WR,                 3'b010, 6'b000000}, // R9 tdc clear
    {4'd9,  K_NS|K_BD|K_EMP,      3'b110, 6'b000000}, // R9 tx tdc
    {4'd9,  K_R1,                 3'b110, 6'b000000},
    {4'd9,  K_WR,                 3'b010, 6'b000000},
    {4'd9,  K_BD|K_EMP,           3'b010, 6'b000000}, // R9 stretch on: no tdc
    {4'd9,  K_NS|K_BD|K_RX,       3'b010, 6'b000000}, // R9 rx, data read
    {4'd6,  K_R1,                 3'b010, 6'b000000},
    {4'd6,  K_SG|K_WR,            3'b011, 6'b000000}, // R6 start set wins
    {4'd10, K_SCL,                3'b011, 6'b000001}, // R10 busy on SCL low
    {4'd6,  K_STP|K_SCL,          3'b011, 6'b000001}, // R6 busy set wins
    {4'd10, K_STP,                3'b011, 6'b000000}  // R10 stop clears busy
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic apply(input logic [19:0] s);
    start_gen   = s[0];  addr_done  = s[1];  addr_nack  = s[2];
    match_sec   = s[3];  match_host = s[4];  match_dev  = s[5];
    match_gc    = s[6];  addr_dir_tx = s[7]; byte_done  = s[8];
    rx_mode     = s[9];  data_unread = s[10]; data_empty = s[11];
    bus_stop    = s[12]; bus_start  = s[13]; rd_stat1   = s[14];
    rd_stat2    = s[15]; wr_data    = s[16]; sda_in     = ~s[17];
    scl_in      = ~s[18]; no_stretch = s[19];
  endtask

  task automatic chk(input string req, input string what,
                     input logic [STAT_W-1:0] got, input logic [STAT_W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; periph_en = 1'b1; pec_en = 1'b0; pec_val = '0;
    apply(K_0);
    repeat (3) @(negedge clk);
    chk("R1", "stat1 in reset", stat1, '0);
    chk("R1", "stat2 in reset", stat2, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i][28:9]);
      @(negedge clk);
      chk($sformatf("R%0d", TBL[i][32:29]), $sformatf("vec %0d stat1", i),
          stat1, {13'b0, TBL[i][8:6]});
      chk($sformatf("R%0d", TBL[i][32:29]), $sformatf("vec %0d stat2", i),
          stat2, {10'b0, TBL[i][5:0]});
      apply(K_0);
    end

    // R7: enable low clears match flags
    apply(K_AD|K_SEC|K_GC);
    @(negedge clk);
    chk("R7", "match loaded", stat2, 16'h0024);
    apply(K_0);
    periph_en = 1'b0;
    @(negedge clk);
    chk("R7", "enable low clears", stat2, 16'h0000);
    apply(K_AD|K_HST);
    @(negedge clk);
    chk("R7", "enable low beats address", stat2, 16'h0000);
    apply(K_0);
    periph_en = 1'b1;

    // R11: PEC field
    pec_en = 1'b1; pec_val = 8'hA5;
    @(negedge clk);
    chk("R11", "pec shown", stat2, 16'hA500);
    pec_val = 8'h3C;
    @(negedge clk);
    chk("R11", "pec follows", stat2, 16'h3C00);
    pec_en = 1'b0;
    @(negedge clk);
    chk("R11", "pec zero when off", stat2, 16'h0000);

    // R1: reset while flags are set
    apply(K_SG|K_SDA|K_AD|K_TX);
    @(negedge clk);
    apply(K_0);
    chk("R1", "flags set before reset", stat1, 16'h0003);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "stat1 after reset", stat1, '0);
    chk("R1", "stat2 after reset", stat2, '0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule